// File: doc/BRIEF.md
# Branch and Next-Address Unit

This combinational unit produces the address of the next instruction for a 32-bit RISC datapath in which every instruction address is word aligned. It takes the current program counter, the instruction's 16-bit offset field and 26-bit jump field, and the two register operands. It also takes a 2-bit branch kind from the decoder and a 2-bit source select. From these it returns the next program counter and the plain incremented address. The incremented address is what a jump-and-link writes into the link register.

Address arithmetic runs on the upper 30 bits of the PC only, with a fixed carry-in of one, so that one addition yields PC+4. When a branch condition holds, the sign-extended offset also enters this addition. In every other case the offset is gated to zero. The same adder therefore serves both straight-line code and taken branches. A final selector chooses among four sources: the adder result, a jump target built from the upper PC nibble, a register target, and a fixed system-call entry address.

Control pins are plain levels with no handshake. Both outputs follow the inputs within the same cycle. No clock or reset is involved.

Top module: `next_addr_unit`

## Requirements
- R1: `incr_pc` equals {pc[31:2]+1, 2'b00} modulo 2^32; pc[1:0] has no effect, and 0xFFFFFFFC wraps to 0.
- R2: When a branch is taken, the adder result is `incr_pc` plus the sign-extended offset times 4, modulo 2^32.
- R3: Branch kind 00 never takes a branch, whatever the operands are; the adder result is then `incr_pc`.
- R4: Branch kind 01 is taken exactly when rs equals rt.
- R5: Branch kind 10 is taken exactly when rs differs from rt.
- R6: Branch kind 11 is taken exactly when rs is negative as a signed value (rs[31] is 1).
- R7: Source select 00 drives `next_pc` with the adder result.
- R8: Source select 01 drives `next_pc` with {pc[31:28], jump_field, 2'b00}.
- R9: Source select 10 drives `next_pc` with {rs[31:2], 2'b00}.
- R10: Source select 11 drives `next_pc` with the parameter `TRAP_ADDR`.
- R11: `incr_pc` is always the plain PC+4, whatever the branch kind, the branch outcome and the source select are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | 32 | Current program counter |
| imm_field | input | 16 | Branch offset in words, signed |
| jump_field | input | 26 | Jump target word index |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| br_kind | input | 2 | 00 none, 01 equal, 10 not equal, 11 negative |
| pc_src | input | 2 | 00 adder, 01 jump, 10 register, 11 system call |
| next_pc | output | 32 | Address of the next instruction |
| incr_pc | output | 32 | PC+4, used for link writes |

## Verification
The bench runs each branch kind with its condition both true and false. For the negative test it includes rs of zero and rs of the largest positive value, which a design that tested magnitude or used an unsigned compare would wrongly take. It wraps the adder at the top of the address space, both on a plain increment and on a taken branch. A design that carried into a 33rd bit or dropped the carry-in would give a wrong result there. It also asserts a taken condition while a jump or the system-call source is selected, to catch an `incr_pc` or `next_pc` that leaked the offset. Misaligned register targets and a non-zero low PC pair check that the low two bits are forced to zero.

// File: rtl/nal_pkg.sv
package nal_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10,
    BR_NEG  = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    SRC_SEQ  = 2'b00,
    SRC_JUMP = 2'b01,
    SRC_REG  = 2'b10,
    SRC_TRAP = 2'b11
  } pc_src_e;
endpackage

// File: rtl/nal_cond.sv
module nal_cond
  import nal_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  br_kind_e        kind,
  output logic            taken
);
  logic same;
  assign same = (rs_val == rt_val);

  always_comb begin
    unique case (kind)
      BR_EQ:   taken = same;
      BR_NE:   taken = !same;
      BR_NEG:  taken = rs_val[XLEN-1];
      default: taken = 1'b0;
    endcase
  end

  // R3: kind 00 never takes a branch
  always_comb begin
    if (!$isunknown(kind) && kind == BR_NONE)
      a_r3_none_not_taken: assert (!taken);
  end
endmodule

// File: rtl/nal_adder.sv
module nal_adder #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  localparam int WORD_W = XLEN - 2
) (
  input  logic [WORD_W-1:0] pc_word,
  input  logic [IMM_W-1:0]  offset,
  input  logic              take,
  output logic [WORD_W-1:0] seq_word,
  output logic [WORD_W-1:0] target_word
);
  logic [WORD_W-1:0] offset_ext;
  logic [WORD_W-1:0] offset_gated;

  assign offset_ext   = {{(WORD_W-IMM_W){offset[IMM_W-1]}}, offset};
  assign offset_gated = take ? offset_ext : '0;
  assign target_word  = pc_word + offset_gated + WORD_W'(1);
  assign seq_word     = pc_word + WORD_W'(1);

  // R3: a branch not taken leaves the adder at the sequential address
  always_comb begin
    if (!$isunknown({take, pc_word}) && !take)
      a_r3_gated_seq: assert (target_word == seq_word);
  end
endmodule

// File: rtl/nal_mux.sv
module nal_mux
  import nal_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              JT_W      = 26,
  parameter logic [XLEN-1:0] TRAP_ADDR = 32'h0000_0080,
  localparam int WORD_W = XLEN - 2,
  localparam int TOP_W  = WORD_W - JT_W
) (
  input  pc_src_e           sel,
  input  logic [WORD_W-1:0] pc_word,
  input  logic [WORD_W-1:0] adder_word,
  input  logic [JT_W-1:0]   jump_field,
  input  logic [WORD_W-1:0] reg_word,
  output logic [XLEN-1:0]   next_pc
);
  logic [WORD_W-1:0] pick;

  always_comb begin
    unique case (sel)
      SRC_SEQ:  pick = adder_word;
      SRC_JUMP: pick = {pc_word[WORD_W-1 -: TOP_W], jump_field};
      SRC_REG:  pick = reg_word;
      default:  pick = TRAP_ADDR[XLEN-1:2];
    endcase
  end

  assign next_pc = {pick, 2'b00};

  // R8: a jump stays inside the current top region of the address space
  always_comb begin
    if (!$isunknown({sel, pc_word}) && sel == SRC_JUMP)
      a_r8_jump_region: assert (next_pc[XLEN-1 -: TOP_W] == pc_word[WORD_W-1 -: TOP_W]);
  end
endmodule

// File: rtl/next_addr_unit.sv
module next_addr_unit
  import nal_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              IMM_W     = 16,
  parameter int              JT_W      = 26,
  parameter logic [XLEN-1:0] TRAP_ADDR = 32'h0000_0080
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm_field,
  input  logic [JT_W-1:0]  jump_field,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic [1:0]       br_kind,
  input  logic [1:0]       pc_src,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  incr_pc
);
  localparam int WORD_W = XLEN - 2;

  logic              take;
  logic [WORD_W-1:0] seq_word;
  logic [WORD_W-1:0] target_word;

  nal_cond #(.XLEN(XLEN)) u_cond (
    .rs_val (rs_val),
    .rt_val (rt_val),
    .kind   (br_kind_e'(br_kind)),
    .taken  (take)
  );

  nal_adder #(.XLEN(XLEN), .IMM_W(IMM_W)) u_adder (
    .pc_word     (pc[XLEN-1:2]),
    .offset      (imm_field),
    .take        (take),
    .seq_word    (seq_word),
    .target_word (target_word)
  );

  nal_mux #(.XLEN(XLEN), .JT_W(JT_W), .TRAP_ADDR(TRAP_ADDR)) u_mux (
    .sel        (pc_src_e'(pc_src)),
    .pc_word    (pc[XLEN-1:2]),
    .adder_word (target_word),
    .jump_field (jump_field),
    .reg_word   (rs_val[XLEN-1:2]),
    .next_pc    (next_pc)
  );

  assign incr_pc = {seq_word, 2'b00};

  // R1, R11: the link address is always four past the aligned PC
  always_comb begin
    if (!$isunknown(pc))
      a_r1_incr_by_four: assert (incr_pc - {pc[XLEN-1:2], 2'b00} == XLEN'(4));
  end

  // R7: with the sequential source and no branch kind, next equals link
  always_comb begin
    if (!$isunknown({pc, pc_src, br_kind}) && pc_src == 2'b00 && br_kind == 2'b00)
      a_r7_seq_matches_incr: assert (next_pc == incr_pc);
  end
endmodule

// File: tb/next_addr_unit_test.sv
module next_addr_unit_test;
  localparam logic [31:0] TRAP = 32'h0040_0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc = '0;
  logic [15:0] imm_field = '0;
  logic [25:0] jump_field = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [1:0]  br_kind = '0;
  logic [1:0]  pc_src = '0;
  logic [31:0] next_pc;
  logic [31:0] incr_pc;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  next_addr_unit #(.TRAP_ADDR(TRAP)) uut (
    .pc(pc), .imm_field(imm_field), .jump_field(jump_field),
    .rs_val(rs_val), .rt_val(rt_val), .br_kind(br_kind),
    .pc_src(pc_src), .next_pc(next_pc), .incr_pc(incr_pc)
  );

  task automatic drive(input logic [31:0] p, input logic [15:0] im,
                       input logic [25:0] jf, input logic [31:0] a,
                       input logic [31:0] b, input logic [1:0] bk,
                       input logic [1:0] ps, input logic [31:0] exp_next,
                       input logic [31:0] exp_incr, input string tag);
    @(posedge clk);
    pc = p; imm_field = im; jump_field = jf; rs_val = a; rt_val = b;
    br_kind = bk; pc_src = ps;
    exp_q.push_back({exp_next, exp_incr});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (next_pc !== e[63:32]) begin
        fails++;
        $display("FAIL %s next_pc actual %h expected %h", t, next_pc, e[63:32]);
      end
      checks++;
      if (incr_pc !== e[31:0]) begin
        fails++;
        $display("FAIL %s incr_pc actual %h expected %h", t, incr_pc, e[31:0]);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(32'h0, 16'h0, 26'h0, 32'h0, 32'h0, 2'b00, 2'b00, 32'h4, 32'h4, "R7 idle");
    drive(32'h0000_1003, 16'h0, 26'h0, 32'h0, 32'h0, 2'b00, 2'b00, 32'h0000_1004, 32'h0000_1004, "R1 low bits");
    drive(32'hFFFF_FFFC, 16'h0, 26'h0, 32'h0, 32'h0, 2'b00, 2'b00, 32'h0, 32'h0, "R1 wrap");
    drive(32'h0000_0100, 16'hFFFF, 26'h0, 32'h5, 32'h5, 2'b01, 2'b00, 32'h0000_0100, 32'h0000_0104, "R4 equal");
    drive(32'h0000_0100, 16'hFFFF, 26'h0, 32'h5, 32'h6, 2'b01, 2'b00, 32'h0000_0104, 32'h0000_0104, "R4 unequal");
    drive(32'h0000_1000, 16'h7FFF, 26'h0, 32'h1, 32'h2, 2'b10, 2'b00, 32'h0002_1000, 32'h0000_1004, "R5 differ");
    drive(32'h0000_1000, 16'h7FFF, 26'h0, 32'h9, 32'h9, 2'b10, 2'b00, 32'h0000_1004, 32'h0000_1004, "R5 same");
    drive(32'h0004_0000, 16'h8000, 26'h0, 32'h8000_0000, 32'h0, 2'b11, 2'b00, 32'h0002_0004, 32'h0004_0004, "R6 negative");
    drive(32'h0004_0000, 16'h8000, 26'h0, 32'h0, 32'h0, 2'b11, 2'b00, 32'h0004_0004, 32'h0004_0004, "R6 zero");
    drive(32'h0004_0000, 16'h8000, 26'h0, 32'h7FFF_FFFF, 32'h0, 2'b11, 2'b00, 32'h0004_0004, 32'h0004_0004, "R6 max positive");
    drive(32'h0000_0200, 16'h0010, 26'h0, 32'h3, 32'h3, 2'b00, 2'b00, 32'h0000_0204, 32'h0000_0204, "R3 kind none");
    drive(32'hFFFF_FFF8, 16'h0004, 26'h0, 32'h7, 32'h7, 2'b01, 2'b00, 32'h0000_000C, 32'hFFFF_FFFC, "R2 branch wrap");
    drive(32'hA000_0000, 16'h0, 26'h3FF_FFFF, 32'h0, 32'h0, 2'b00, 2'b01, 32'hAFFF_FFFC, 32'hA000_0004, "R8 jump");
    drive(32'h5000_0010, 16'h0100, 26'h000_0010, 32'h1, 32'h1, 2'b01, 2'b01, 32'h5000_0040, 32'h5000_0014, "R11 jump with taken");
    drive(32'h0000_0300, 16'h0, 26'h0, 32'h1234_5677, 32'h0, 2'b00, 2'b10, 32'h1234_5674, 32'h0000_0304, "R9 register");
    drive(32'h0000_0700, 16'h0, 26'h0, 32'h0, 32'h0, 2'b00, 2'b11, TRAP, 32'h0000_0704, "R10 trap");
    drive(32'h0000_0700, 16'h0040, 26'h0, 32'h1, 32'h2, 2'b10, 2'b11, TRAP, 32'h0000_0704, "R11 trap with taken");
    wait (exp_q.size() == 0);
    @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired with %0d items pending", exp_q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule